// File: doc/BRIEF.md
# Block-Device DMA Transfer Sequencer

This block drives one storage command's data phase. The command is moved in chunks between a descriptor-driven memory channel and a block storage device. A start pulse names the command (read, write or trim), the drive kind (disk or optical) and the starting address on the medium. The sequencer loads the byte count the command must move, clears its running byte index, sets its active flag and kicks the channel.

Each time the channel offers a memory chunk (an address and a length), the sequencer works out the byte offset on the device. A disk counts in 512-byte sectors and an optical drive counts in 2048-byte blocks. The sequencer issues one device request for the whole chunk, then advances its counters and waits for the device to answer. After the answer it hands the chunk back to the channel. It also closes the command when no bytes remain, or when the device reported an error.

An optical transfer whose block number is all ones carries packet data that is not block data. That data is copied directly with no offset, and the command completes at once. A chunk that arrives while no command is active parks the channel until it is restarted.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset all output strobes are low, `active_o` is low and no request is pending.
- R2: A start with a legal command raises `kick_o` for one cycle and sets `active_o`, both in the cycle after the start. The byte count loaded is `start_nsect_i`×512 for a disk and `start_pkt_i` for an optical drive.
- R3: A disk start with command code 2'b11 is illegal. It produces a one-cycle `cmd_err_o`, no `kick_o`, and leaves `active_o` low.
- R4: A disk request carries offset `start_lba_i`×512 plus the running index, computed without overflow for a 32-bit sector number. Its `req_op_o` is 2'b00 for read, 2'b01 for write and 2'b10 for trim.
- R5: An optical request carries offset block×2048 plus the running index, and its `req_op_o` is always read (2'b00), whatever command code was given.
- R6: A chunk offered while `active_o` is low produces a one-cycle `park_o`, with no request and no `chunk_done_o`.
- R7: An accepted chunk issues one request with the chunk's address and length. The running index then grows by that length, so the next chunk's offset is larger by the same amount.
- R8: When the device answers without error and bytes remain, `chunk_done_o` pulses, no completion is signalled, and `active_o` stays high.
- R9: When the remaining count is zero or negative, at a device answer or when a chunk arrives, `cmd_done_o` and `chunk_done_o` pulse together and `active_o` clears.
- R10: A zero-length chunk while bytes remain pulses only `chunk_done_o`. No request is issued and the command stays open.
- R11: For an optical command whose block number is all ones, a chunk issues a copy request (`req_op_o` = 2'b11). Its length is the smaller of the remaining count and the chunk length. `cmd_done_o` and `chunk_done_o` pulse with it and `active_o` clears.
- R12: A device answer flagged as an error pulses `cmd_err_o` and `chunk_done_o`, never `cmd_done_o`, and clears `active_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a command |
| start_optical_i | input | 1 | 1: optical drive, 0: disk |
| start_cmd_i | input | 2 | Disk command: 00 read, 01 write, 10 trim, 11 illegal |
| start_lba_i | input | LBA_W | Starting sector (disk) or block number (optical) |
| start_nsect_i | input | SECT_W | Sector count for a disk |
| start_pkt_i | input | PKT_W | Packet transfer size in bytes for an optical drive |
| kick_o | output | 1 | Pulse that restarts the memory channel |
| active_o | output | 1 | Command in progress |
| chunk_valid_i | input | 1 | Channel offers a chunk |
| chunk_addr_i | input | ADDR_W | Memory address of the chunk |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| chunk_done_o | output | 1 | Chunk returned to the channel |
| park_o | output | 1 | Chunk refused: no command is active |
| req_valid_o | output | 1 | Device request strobe |
| req_op_o | output | 2 | 00 read, 01 write, 10 trim, 11 direct copy |
| req_addr_o | output | ADDR_W | Memory address of the request |
| req_len_o | output | LEN_W | Request length in bytes |
| req_offset_o | output | OFF_W | Byte offset on the device |
| dev_done_i | input | 1 | Device finished the outstanding request |
| dev_err_i | input | 1 | Qualifies `dev_done_i` as a failure |
| cmd_done_o | output | 1 | Command completed successfully |
| cmd_err_o | output | 1 | Command ended in error |

## Verification
The hardest case to reach is a chunk arriving while the command is active but its remaining count is already zero or below. A normal transfer never gets there, because the device answer that drains the count closes the command first. The stimulus reaches it by starting a disk command with a sector count of zero and then offering a chunk. The check is that completion comes with no device request. The negative-count path is reached by offering a single chunk longer than the whole command.

// File: rtl/dma_xfer_seq_pkg.sv
package dma_xfer_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_TRIM  = 2'b10,
    OP_COPY  = 2'b11
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } state_e;

  localparam int unsigned DISK_SHIFT = 9;
  localparam int unsigned OPT_SHIFT  = 11;
  localparam int unsigned MIN_OFF_W  = 48;
endpackage

// File: rtl/dma_xfer_seq_count.sv
module dma_xfer_seq_count
  import dma_xfer_seq_pkg::*;
#(
  parameter int unsigned SECT_W = 16,
  parameter int unsigned PKT_W  = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned REM_W  = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    load_optical_i,
  input  logic [SECT_W-1:0]       nsect_i,
  input  logic [PKT_W-1:0]        pkt_i,
  input  logic                    consume_i,
  input  logic [LEN_W-1:0]        len_i,
  output logic signed [REM_W-1:0] remain_o,
  output logic [REM_W-1:0]        index_o
);
  logic signed [REM_W-1:0] remain_q, remain_d;
  logic [REM_W-1:0]        index_q, index_d;
  logic [REM_W-1:0]        load_val;
  logic [REM_W-1:0]        len_ext;

  assign len_ext = REM_W'(len_i);

  always_comb begin
    if (load_optical_i) load_val = REM_W'(pkt_i);
    else                load_val = REM_W'(nsect_i) << DISK_SHIFT;
  end

  always_comb begin
    remain_d = remain_q;
    index_d  = index_q;
    if (load_i) begin
      remain_d = $signed(load_val);
      index_d  = '0;
    end else if (consume_i) begin
      remain_d = remain_q - $signed(len_ext);
      index_d  = index_q + len_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      index_q  <= '0;
    end else if (load_i || consume_i) begin
      remain_q <= remain_d;
      index_q  <= index_d;
    end
  end

  assign remain_o = remain_q;
  assign index_o  = index_q;
endmodule

// File: rtl/dma_xfer_seq_offset.sv
module dma_xfer_seq_offset
  import dma_xfer_seq_pkg::*;
#(
  parameter int unsigned LBA_W = 32,
  parameter int unsigned IDX_W = 28,
  parameter int unsigned OFF_W = 48
) (
  input  logic             optical_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic [IDX_W-1:0] index_i,
  output logic [OFF_W-1:0] offset_o
);
  logic [OFF_W-1:0] lba_ext;
  logic [OFF_W-1:0] base;

  assign lba_ext = OFF_W'(lba_i);

  always_comb begin
    if (optical_i) base = lba_ext << OPT_SHIFT;
    else           base = lba_ext << DISK_SHIFT;
  end

  assign offset_o = base + OFF_W'(index_i);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_seq_pkg::*;
#(
  parameter int unsigned LBA_W  = 32,
  parameter int unsigned SECT_W = 16,
  parameter int unsigned PKT_W  = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned DREM_W = SECT_W + DISK_SHIFT,
  localparam int unsigned MAXB_W = (DREM_W > PKT_W) ? DREM_W : PKT_W,
  localparam int unsigned MAX2_W = (MAXB_W > LEN_W) ? MAXB_W : LEN_W,
  localparam int unsigned REM_W  = MAX2_W + 2,
  localparam int unsigned RAW_OFF_W = LBA_W + OPT_SHIFT + 1,
  localparam int unsigned OFF_W  = (RAW_OFF_W > MIN_OFF_W) ? RAW_OFF_W : MIN_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_optical_i,
  input  logic [1:0]        start_cmd_i,
  input  logic [LBA_W-1:0]  start_lba_i,
  input  logic [SECT_W-1:0] start_nsect_i,
  input  logic [PKT_W-1:0]  start_pkt_i,
  output logic              kick_o,
  output logic              active_o,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  output logic              chunk_done_o,
  output logic              park_o,
  output logic              req_valid_o,
  output logic [1:0]        req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [OFF_W-1:0]  req_offset_o,
  input  logic              dev_done_i,
  input  logic              dev_err_i,
  output logic              cmd_done_o,
  output logic              cmd_err_o
);
  state_e            state_q, state_d;
  logic              active_q, active_d;
  logic              optical_q, optical_d;
  op_e               cmd_q, cmd_d;
  logic [LBA_W-1:0]  lba_q, lba_d;

  logic              kick_q, kick_d;
  logic              cdone_q, cdone_d;
  logic              park_q, park_d;
  logic              rvalid_q, rvalid_d;
  op_e               rop_q, rop_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [LEN_W-1:0]  rlen_q, rlen_d;
  logic [OFF_W-1:0]  roff_q, roff_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic                    load, consume;
  logic signed [REM_W-1:0] remain;
  logic [REM_W-1:0]        index;
  logic [OFF_W-1:0]        offset;
  logic                    rem_pos;
  logic                    raw_pkt;
  logic [REM_W-1:0]        len_ext;
  logic [LEN_W-1:0]        copy_len;

  dma_xfer_seq_count #(
    .SECT_W(SECT_W), .PKT_W(PKT_W), .LEN_W(LEN_W), .REM_W(REM_W)
  ) u_count (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .load_optical_i(start_optical_i),
    .nsect_i(start_nsect_i), .pkt_i(start_pkt_i),
    .consume_i(consume), .len_i(chunk_len_i),
    .remain_o(remain), .index_o(index)
  );

  dma_xfer_seq_offset #(
    .LBA_W(LBA_W), .IDX_W(REM_W), .OFF_W(OFF_W)
  ) u_offset (
    .optical_i(optical_q), .lba_i(lba_q), .index_i(index), .offset_o(offset)
  );

  assign rem_pos  = (remain > 0);
  assign raw_pkt  = optical_q && (&lba_q);
  assign len_ext  = REM_W'(chunk_len_i);
  assign copy_len = ($unsigned(remain) < len_ext) ? remain[LEN_W-1:0] : chunk_len_i;

  always_comb begin
    state_d   = state_q;
    active_d  = active_q;
    optical_d = optical_q;
    cmd_d     = cmd_q;
    lba_d     = lba_q;
    rop_d     = rop_q;
    raddr_d   = raddr_q;
    rlen_d    = rlen_q;
    roff_d    = roff_q;
    kick_d    = 1'b0;
    cdone_d   = 1'b0;
    park_d    = 1'b0;
    rvalid_d  = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    load      = 1'b0;
    consume   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!start_optical_i && (start_cmd_i == OP_COPY)) begin
            err_d    = 1'b1;
            active_d = 1'b0;
          end else begin
            kick_d    = 1'b1;
            active_d  = 1'b1;
            optical_d = start_optical_i;
            cmd_d     = start_optical_i ? OP_READ : op_e'(start_cmd_i);
            lba_d     = start_lba_i;
            load      = 1'b1;
          end
        end else if (chunk_valid_i) begin
          if (!active_q) begin
            park_d = 1'b1;
          end else if (!rem_pos) begin
            done_d   = 1'b1;
            cdone_d  = 1'b1;
            active_d = 1'b0;
          end else if (chunk_len_i == '0) begin
            cdone_d = 1'b1;
          end else if (raw_pkt) begin
            rvalid_d = 1'b1;
            rop_d    = OP_COPY;
            raddr_d  = chunk_addr_i;
            rlen_d   = copy_len;
            roff_d   = '0;
            done_d   = 1'b1;
            cdone_d  = 1'b1;
            active_d = 1'b0;
          end else begin
            rvalid_d = 1'b1;
            rop_d    = cmd_q;
            raddr_d  = chunk_addr_i;
            rlen_d   = chunk_len_i;
            roff_d   = offset;
            consume  = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (dev_done_i) begin
          cdone_d = 1'b1;
          state_d = ST_IDLE;
          if (dev_err_i) begin
            err_d    = 1'b1;
            active_d = 1'b0;
          end else if (!rem_pos) begin
            done_d   = 1'b1;
            active_d = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      active_q  <= 1'b0;
      optical_q <= 1'b0;
      cmd_q     <= OP_READ;
      lba_q     <= '0;
      kick_q    <= 1'b0;
      cdone_q   <= 1'b0;
      park_q    <= 1'b0;
      rvalid_q  <= 1'b0;
      rop_q     <= OP_READ;
      raddr_q   <= '0;
      rlen_q    <= '0;
      roff_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      active_q  <= active_d;
      optical_q <= optical_d;
      cmd_q     <= cmd_d;
      lba_q     <= lba_d;
      kick_q    <= kick_d;
      cdone_q   <= cdone_d;
      park_q    <= park_d;
      rvalid_q  <= rvalid_d;
      done_q    <= done_d;
      err_q     <= err_d;
      if (rvalid_d) begin
        rop_q   <= rop_d;
        raddr_q <= raddr_d;
        rlen_q  <= rlen_d;
        roff_q  <= roff_d;
      end
    end
  end

  assign kick_o       = kick_q;
  assign active_o     = active_q;
  assign chunk_done_o = cdone_q;
  assign park_o       = park_q;
  assign req_valid_o  = rvalid_q;
  assign req_op_o     = rop_q;
  assign req_addr_o   = raddr_q;
  assign req_len_o    = rlen_q;
  assign req_offset_o = roff_q;
  assign cmd_done_o   = done_q;
  assign cmd_err_o    = err_q;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kick_o,
  input logic             active_o,
  input logic             chunk_done_o,
  input logic             park_o,
  input logic             req_valid_o,
  input logic [1:0]       req_op_o,
  input logic [LEN_W-1:0] req_len_o,
  input logic             cmd_done_o,
  input logic             cmd_err_o
);
  a_r2_kick_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> active_o);
  a_r2_rise_needs_kick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> kick_o);
  a_r6_park_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    park_o |-> (!active_o && !req_valid_o && !chunk_done_o));
  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_op_o != 2'b11) |=> !req_valid_o);
  a_r9_done_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_o |-> (!active_o && chunk_done_o));
  a_r10_no_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_len_o != '0));
  a_r12_err_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_o |-> (!cmd_done_o && !active_o));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kick_o(kick_o), .active_o(active_o),
  .chunk_done_o(chunk_done_o), .park_o(park_o), .req_valid_o(req_valid_o),
  .req_op_o(req_op_o), .req_len_o(req_len_o),
  .cmd_done_o(cmd_done_o), .cmd_err_o(cmd_err_o)
);

// File: tb/dma_xfer_seq_tb.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb;
  localparam int OFF_W = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, start_optical_i;
  logic [1:0]  start_cmd_i;
  logic [31:0] start_lba_i;
  logic [15:0] start_nsect_i;
  logic [23:0] start_pkt_i;
  logic        kick_o, active_o;
  logic        chunk_valid_i;
  logic [31:0] chunk_addr_i;
  logic [15:0] chunk_len_i;
  logic        chunk_done_o, park_o, req_valid_o;
  logic [1:0]  req_op_o;
  logic [31:0] req_addr_o;
  logic [15:0] req_len_o;
  logic [OFF_W-1:0] req_offset_o;
  logic        dev_done_i, dev_err_i;
  logic        cmd_done_o, cmd_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .start_optical_i(start_optical_i), .start_cmd_i(start_cmd_i),
    .start_lba_i(start_lba_i), .start_nsect_i(start_nsect_i), .start_pkt_i(start_pkt_i),
    .kick_o(kick_o), .active_o(active_o),
    .chunk_valid_i(chunk_valid_i), .chunk_addr_i(chunk_addr_i), .chunk_len_i(chunk_len_i),
    .chunk_done_o(chunk_done_o), .park_o(park_o),
    .req_valid_o(req_valid_o), .req_op_o(req_op_o), .req_addr_o(req_addr_o),
    .req_len_o(req_len_o), .req_offset_o(req_offset_o),
    .dev_done_i(dev_done_i), .dev_err_i(dev_err_i),
    .cmd_done_o(cmd_done_o), .cmd_err_o(cmd_err_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a start pulse; outputs are sampled one cycle later.
  task automatic do_start(input logic opt, input logic [1:0] cmd, input logic [31:0] lba,
                          input logic [15:0] ns, input logic [23:0] pkt);
    start_i = 1'b1; start_optical_i = opt; start_cmd_i = cmd;
    start_lba_i = lba; start_nsect_i = ns; start_pkt_i = pkt;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_chunk(input logic [31:0] addr, input logic [15:0] len);
    chunk_valid_i = 1'b1; chunk_addr_i = addr; chunk_len_i = len;
    @(negedge clk);
    chunk_valid_i = 1'b0;
  endtask

  task automatic do_dev(input logic err);
    @(negedge clk);
    dev_done_i = 1'b1; dev_err_i = err;
    @(negedge clk);
    dev_done_i = 1'b0; dev_err_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 kick", kick_o, 0);
    check("R1 active", active_o, 0);
    check("R1 chunk_done", chunk_done_o, 0);
    check("R1 req_valid", req_valid_o, 0);
    check("R1 done/err/park", {cmd_done_o, cmd_err_o, park_o}, 0);
  endtask

  task automatic t_park;
    do_chunk(32'h100, 16'h200);
    check("R6 park", park_o, 1);
    check("R6 no request", req_valid_o, 0);
    check("R6 no chunk_done", chunk_done_o, 0);
  endtask

  task automatic t_illegal;
    do_start(1'b0, 2'b11, 32'h5, 16'd4, 24'h0);
    check("R3 err pulse", cmd_err_o, 1);
    check("R3 no kick", kick_o, 0);
    check("R3 inactive", active_o, 0);
  endtask

  task automatic t_disk_read;
    do_start(1'b0, 2'b00, 32'h10, 16'd2, 24'h0);
    check("R2 kick", kick_o, 1);
    check("R2 active", active_o, 1);
    do_chunk(32'h1000, 16'h200);
    check("R7 req_valid", req_valid_o, 1);
    check("R4 read op", req_op_o, 2'b00);
    check("R7 addr", req_addr_o, 32'h1000);
    check("R7 len", req_len_o, 16'h200);
    check("R4 offset", req_offset_o, 48'h2000);
    do_dev(1'b0);
    check("R8 chunk_done", chunk_done_o, 1);
    check("R8 still open", {cmd_done_o, active_o}, 2'b01);
    do_chunk(32'h3000, 16'h200);
    check("R7 offset advanced", req_offset_o, 48'h2200);
    do_dev(1'b0);
    check("R9 cmd_done", cmd_done_o, 1);
    check("R9 chunk_done", chunk_done_o, 1);
    check("R9 active clear", active_o, 0);
  endtask

  task automatic t_disk_write_wide;
    do_start(1'b0, 2'b01, 32'hFFFF_FFFE, 16'd1, 24'h0);
    do_chunk(32'h4000, 16'h400);
    check("R4 write op", req_op_o, 2'b01);
    check("R4 wide offset", req_offset_o, 48'h1FF_FFFF_FC00);
    do_dev(1'b0);
    check("R9 overshoot completes", {cmd_done_o, active_o}, 2'b10);
  endtask

  task automatic t_trim_err;
    do_start(1'b0, 2'b10, 32'h1, 16'd1, 24'h0);
    do_chunk(32'h5000, 16'h200);
    check("R4 trim op", req_op_o, 2'b10);
    do_dev(1'b1);
    check("R12 err", cmd_err_o, 1);
    check("R12 no done", cmd_done_o, 0);
    check("R12 chunk_done", chunk_done_o, 1);
    check("R12 active clear", active_o, 0);
  endtask

  task automatic t_optical;
    do_start(1'b1, 2'b01, 32'h3, 16'd0, 24'h1000);
    check("R2 optical kick", kick_o, 1);
    do_chunk(32'h6000, 16'h0);
    check("R10 chunk_done", chunk_done_o, 1);
    check("R10 no request", req_valid_o, 0);
    check("R10 still active", active_o, 1);
    do_chunk(32'h6000, 16'h800);
    check("R5 op read", req_op_o, 2'b00);
    check("R5 offset", req_offset_o, 48'h1800);
    do_dev(1'b0);
    check("R8 optical open", {chunk_done_o, cmd_done_o, active_o}, 3'b101);
    do_chunk(32'h7000, 16'h800);
    check("R5 offset advanced", req_offset_o, 48'h2000);
    do_dev(1'b0);
    check("R9 optical done", {cmd_done_o, active_o}, 2'b10);
  endtask

  task automatic t_raw;
    do_start(1'b1, 2'b00, 32'hFFFF_FFFF, 16'd0, 24'h24);
    do_chunk(32'h8000, 16'h100);
    check("R11 copy op", req_op_o, 2'b11);
    check("R11 len clipped", req_len_o, 16'h24);
    check("R11 done", {cmd_done_o, chunk_done_o, active_o}, 3'b110);
    do_start(1'b1, 2'b00, 32'hFFFF_FFFF, 16'd0, 24'h300);
    do_chunk(32'h9000, 16'h80);
    check("R11 chunk smaller", req_len_o, 16'h80);
    check("R11 addr", req_addr_o, 32'h9000);
  endtask

  task automatic t_zero_count;
    do_start(1'b0, 2'b00, 32'h0, 16'd0, 24'h0);
    do_chunk(32'hA000, 16'h200);
    check("R9 zero count done", cmd_done_o, 1);
    check("R9 zero count no request", req_valid_o, 0);
    check("R9 zero count active", active_o, 0);
    do_chunk(32'hA000, 16'h200);
    check("R6 park after done", park_o, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 0; start_optical_i = 0; start_cmd_i = 0; start_lba_i = 0;
    start_nsect_i = 0; start_pkt_i = 0; chunk_valid_i = 0; chunk_addr_i = 0;
    chunk_len_i = 0; dev_done_i = 0; dev_err_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_park();
        t_illegal();
        t_disk_read();
        t_disk_write_wide();
        t_trim_err();
        t_optical();
        t_raw();
        t_zero_count();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule